// File: doc/BRIEF.md
# FSK Zero-Crossing Demodulator

This block turns a squared frequency-shift-keyed receive signal back into NRZ data. An external comparator has already sliced the band-limited line signal into a single-bit square wave. The block brings that wave into the local clock domain and counts clock cycles between successive transitions of either polarity. It then decides, at every transition, whether the half-period just measured belongs to the low (mark) tone or the high (space) tone. With a 460.8 kHz time base, a 1200 Hz half-period lasts 192 clocks and a 2200 Hz half-period lasts about 105 clocks. A fixed threshold between the two separates them.

The recovered bit is qualified by two enables. The first is a carrier-detect input from a level detector. The second is the active-low request-to-send, which marks that the local transmitter owns the line. When either enable is inactive, the receive path is parked: the output idles at mark, transitions are not evaluated, and the interval measurement restarts from its long, saturated value. This gives half-duplex behaviour, and it means a UART behind the block sees a clean idle line.

Top module: `fsk_zc_demod`

## Requirements
- R1: The comparator input passes through two synchronising flip-flops. An input change first sampled at rising edge k alters `rx_data` just after rising edge k+2, and not before.
- R2: The measured interval is the number of clock cycles between two consecutive detected transitions, counting rising and falling transitions alike.
- R3: An interval greater than 148 clocks is a mark and drives `rx_data` to 1. An interval of 148 clocks or fewer is a space and drives `rx_data` to 0. A steady 1200 Hz square wave (192-clock halves) therefore yields 1, and a steady 2200 Hz wave (105-clock halves) yields 0.
- R4: The interval counter stops at 255 instead of wrapping. A gap of any length above 255 clocks is therefore classified as a mark.
- R5: While `carrier_ok` is 0, `rx_data` is 1 and input transitions have no effect. After `carrier_ok` returns to 1, the first transition is judged against the saturated count, so it yields a mark.
- R6: While `rts_n` is 0 (transmit active), `rx_data` is 1 and input transitions have no effect, with the same restart rule as R5 once `rts_n` returns to 1.
- R7: After synchronous reset, `rx_data` is 1.
- R8: While receive is enabled, the held decision changes only at a detected transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 460.8 kHz time base |
| rst | input | 1 | Synchronous reset, active high |
| cmp_in | input | 1 | Squared receive signal from the external comparator (asynchronous) |
| carrier_ok | input | 1 | Carrier detected, active high |
| rts_n | input | 1 | Request to send, active low; low disables receive |
| rx_data | output | 1 | Recovered NRZ data, 1 = mark |

## Verification
The main function is exercised with the following stimulus:
- Steady square waves at the two nominal half-periods (192 and 105 clocks), which tell mark from space.
- Intervals of exactly 148 and 149 clocks, which pin the threshold to one side.
- A 400-clock gap, which would read as a space if the counter wrapped but reads as a mark when it saturates.

Carrier loss and transmit requests are applied in the middle of a space tone. The bench then checks that the output idles high and that the first transition after re-enable reads as a mark. A single isolated transition is timed cycle by cycle to fix the two-flop latency.

// File: rtl/fskdm_pkg.sv
package fskdm_pkg;

    // Default interval counter width and decision threshold (clocks).
    localparam int DEF_CNT_W     = 8;
    localparam int DEF_THRESH    = 148;
    localparam int DEF_SYNC_DEPTH = 2;

    typedef enum logic {
        TONE_SPACE = 1'b0,
        TONE_MARK  = 1'b1
    } tone_e;

    // Output of the synchroniser stage.
    typedef struct packed {
        logic level;      // synchronised comparator level
        logic toggled;    // a transition was seen this cycle
    } sync_t;

    // Classify a measured half-period.
    function automatic tone_e classify(input int unsigned len, input int unsigned thresh);
        return (len > thresh) ? TONE_MARK : TONE_SPACE;
    endfunction

endpackage

// File: rtl/fskdm_sync.sv
module fskdm_sync
    import fskdm_pkg::*;
#(
    parameter int DEPTH = DEF_SYNC_DEPTH
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  raw_in,
    output sync_t sync_o
);
    logic [DEPTH-1:0] chain_q;
    logic             last_q;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= raw_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[DEPTH-1];
    end

    always_comb begin
        sync_o.level   = chain_q[DEPTH-1];
        sync_o.toggled = chain_q[DEPTH-1] ^ last_q;
    end

endmodule

// File: rtl/fskdm_interval.sv
module fskdm_interval
    import fskdm_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             toggled,
    output logic [CNT_W-1:0] length
);
    localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    // Count cycles since the last transition; stick at SAT.
    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt_q <= SAT;
        end else if (toggled) begin
            cnt_q <= ONE;
        end else if (cnt_q != SAT) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign length = cnt_q;

    // R4: a saturated count with no transition stays saturated.
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == SAT && !toggled) |=> (cnt_q == SAT));

    // R2: a transition while enabled restarts the measurement at one.
    p_restart_r2: assert property (@(posedge clk) disable iff (rst)
        (enable && toggled) |=> (cnt_q == ONE));

endmodule

// File: rtl/fskdm_decide.sv
module fskdm_decide
    import fskdm_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int THRESH = DEF_THRESH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             toggled,
    input  logic [CNT_W-1:0] length,
    output logic             bit_o
);
    tone_e tone_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            tone_q <= TONE_MARK;
        end else if (toggled) begin
            tone_q <= classify(int'(length), THRESH);
        end
    end

    // Qualification: idle mark whenever receive is not enabled.
    assign bit_o = enable ? (tone_q == TONE_MARK) : 1'b1;

    // R5/R6: a disabled cycle leaves the decision parked at mark.
    p_idle_mark_r5: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (tone_q == TONE_MARK));

    // R8: no transition while enabled keeps the decision steady.
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (enable && !toggled) |=> $stable(tone_q));

    // R7: output idles high right after reset.
    p_reset_mark_r7: assert property (@(posedge clk)
        rst |=> (tone_q == TONE_MARK));

endmodule

// File: rtl/fsk_zc_demod.sv
module fsk_zc_demod
    import fskdm_pkg::*;
#(
    parameter int CNT_W      = DEF_CNT_W,
    parameter int THRESH     = DEF_THRESH,
    parameter int SYNC_DEPTH = DEF_SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic cmp_in,
    input  logic carrier_ok,
    input  logic rts_n,
    output logic rx_data
);
    sync_t            sync_s;
    logic             rx_en;
    logic [CNT_W-1:0] len_s;

    // Receive only with carrier present and transmitter idle.
    assign rx_en = carrier_ok & rts_n;

    fskdm_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_in (cmp_in),
        .sync_o (sync_s)
    );

    fskdm_interval #(.CNT_W(CNT_W)) u_interval (
        .clk     (clk),
        .rst     (rst),
        .enable  (rx_en),
        .toggled (sync_s.toggled),
        .length  (len_s)
    );

    fskdm_decide #(.CNT_W(CNT_W), .THRESH(THRESH)) u_decide (
        .clk     (clk),
        .rst     (rst),
        .enable  (rx_en),
        .toggled (sync_s.toggled),
        .length  (len_s),
        .bit_o   (rx_data)
    );

    // R5/R6: a disabled receive path always presents mark at the port.
    p_qualified_r6: assert property (@(posedge clk) disable iff (rst)
        (!carrier_ok || !rts_n) |-> rx_data);

endmodule

// File: tb/sim_fsk_zc_demod.sv
module sim_fsk_zc_demod;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmp_in = 1'b0;
    logic carrier_ok = 1'b1;
    logic rts_n = 1'b1;
    logic rx_data;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fsk_zc_demod u0 (
        .clk(clk), .rst(rst), .cmp_in(cmp_in),
        .carrier_ok(carrier_ok), .rts_n(rts_n), .rx_data(rx_data)
    );

    // Behavioural reference: history queue of samples, integer gap counter.
    bit hist[$];
    int gap = 255;
    bit m_bit = 1;

    always @(posedge clk) begin
        if (rst) begin
            hist = '{0, 0, 0};
            gap = 255;
            m_bit = 1;
        end else begin
            if (!(carrier_ok && rts_n)) begin
                gap = 255;
                m_bit = 1;
            end else if (hist[1] != hist[2]) begin
                m_bit = (gap > 148);
                gap = 1;
            end else if (gap < 255) begin
                gap = gap + 1;
            end
            hist.push_front(cmp_in);
            void'(hist.pop_back());
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: rx_data=%0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model (R1, R2, R8).
    always @(negedge clk) begin
        if (!rst && !done) begin
            int exp_v;
            exp_v = (carrier_ok && rts_n) ? int'(m_bit) : 1;
            chk(rx_data == exp_v[0], "R1/R2/R8 model", rx_data, exp_v);
        end
    end

    task automatic halves(input int len, input int count);
        for (int i = 0; i < count; i++) begin
            cmp_in = ~cmp_in;
            repeat (len) @(negedge clk);
        end
    endtask

    task automatic expect_bit(input bit e, input string req);
        chk(rx_data == e, req, rx_data, e);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_bit(1, "R7 reset idle mark");

        halves(192, 10);
        expect_bit(1, "R3 1200 Hz mark");
        halves(105, 10);
        expect_bit(0, "R3 2200 Hz space");
        halves(192, 4);
        expect_bit(1, "R3 back to mark");
        halves(105, 4);
        expect_bit(0, "R2 space after mark");

        // R3 threshold boundary
        halves(148, 3);
        expect_bit(0, "R3 interval 148 is space");
        halves(149, 3);
        expect_bit(1, "R3 interval 149 is mark");
        halves(105, 3);
        expect_bit(0, "R3 space again");

        // R4 saturation: 400-clock gap must not wrap to 144
        halves(400, 1);
        expect_bit(0, "R4 space before gap edge");
        halves(105, 1);
        expect_bit(1, "R4 long gap reads mark");
        halves(105, 3);
        expect_bit(0, "R4 space after gap");

        // R1 latency: 192-clock interval then one transition
        repeat (87) @(negedge clk);
        cmp_in = ~cmp_in;
        @(negedge clk); expect_bit(0, "R1 unchanged after 1 edge");
        @(negedge clk); expect_bit(0, "R1 unchanged after 2 edges");
        @(negedge clk); expect_bit(1, "R1 changed after 3 edges");
        halves(105, 3);
        expect_bit(0, "R1 space restored");

        // R5 carrier loss during a space tone
        carrier_ok = 1'b0;
        @(negedge clk);
        expect_bit(1, "R5 no carrier idles mark");
        halves(105, 4);
        expect_bit(1, "R5 edges ignored without carrier");
        carrier_ok = 1'b1;
        halves(105, 1);
        expect_bit(1, "R5 first edge after carrier is mark");
        halves(105, 2);
        expect_bit(0, "R5 space resumes");

        // R6 transmit active
        rts_n = 1'b0;
        @(negedge clk);
        expect_bit(1, "R6 transmit idles mark");
        halves(105, 4);
        expect_bit(1, "R6 edges ignored while transmitting");
        rts_n = 1'b1;
        halves(105, 1);
        expect_bit(1, "R6 first edge after transmit is mark");
        halves(105, 2);
        expect_bit(0, "R6 space resumes");

        // R8 long quiet while enabled keeps the space decision
        repeat (600) @(negedge clk);
        expect_bit(0, "R8 held without edges");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule